// File: doc/BRIEF.md
# Dual-Exponent Simultaneous Exponentiation Sequencer

This block is the control side of a modular exponentiation engine that evaluates g0^e0 · g1^e1 mod m. It does no arithmetic. It tells an external modular multiplier which operands to combine and where to write each result. The multiplier is reached through a start/done handshake with a fixed but long latency. Four operand slots are assumed. Slot 0 holds g0 and slot 1 holds g1, both already converted to the multiplier's residue form. Slot 2 holds their product, and slot 3 is the running accumulator.

The host first fills an entry queue with exponent material. Each 32-bit entry holds a 16-bit slice of e1 in its upper half and the slice of e0 at the same bit positions in its lower half. The most significant slices go in first. The host then pulses start with auto_run high. For every bit pair, scanned from the top of each slice downwards, the sequencer orders one squaring of the accumulator. It then orders a multiply by the slot that the pair selects, or no multiply when both bits are zero. When the last pair is finished and the queue is empty, the block pulses ready.

With auto_run low, a start pulse instead issues one multiplication whose x, y and destination codes come straight from the host. The host uses this for pre- and post-conversion steps.

Top module: `simexp_seq`

## Requirements
- R1: Each queue entry carries e1 bits [15:0] of a slice in entry bits [31:16] and the matching e0 bits in entry bits [15:0]. Entries are consumed in push order, first-pushed being the most significant slice, and within an entry bit 15 is processed first.
- R2: The queue holds FIFO_DEPTH entries and raises fifo_full while it holds that many. A push while full is discarded and raises fifo_drop for exactly the cycle after that push edge. fifo_drop is low in every other cycle.
- R3: In auto-run, every bit pair begins with one squaring command: mul_x = mul_y = mul_dst = 3.
- R4: After the squaring completes, the pair {e1 bit, e0 bit} selects the multiply: 01 gives mul_y = 0, 10 gives mul_y = 1, 11 gives mul_y = 2, each with mul_x = 3 and mul_dst = 3. Pair 00 issues no multiply.
- R5: After a run over N entries, the accumulator written by the multiplier equals g0^E0 · g1^E1 mod m, where E0 and E1 are the concatenated slices. Exactly 16·N squarings are issued.
- R6: In auto-run, ready goes high for one cycle. It is visible two cycles after the cycle in which the final mul_done was high, and only once the queue is empty.
- R7: A start with auto_run high and an empty queue raises ready in the next cycle and issues no multiplier command.
- R8: A start with auto_run low issues one command in the next cycle carrying the host's x_sel, y_sel and dst_sel. ready is visible in the cycle after mul_done.
- R9: A start while a run is in progress is ignored. A mul_done while idle is ignored: it produces no ready and no command.
- R10: mul_start is a one-cycle pulse, and no new command is issued while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_din | input | 32 | Exponent entry: e1 slice high, e0 slice low |
| fifo_push | input | 1 | Write fifo_din into the queue |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH entries |
| fifo_drop | output | 1 | Previous push was discarded |
| start | input | 1 | One-cycle request to begin |
| auto_run | input | 1 | High: full exponentiation; low: single command |
| x_sel | input | 2 | Single-mode x operand slot |
| y_sel | input | 2 | Single-mode y operand slot |
| dst_sel | input | 2 | Single-mode destination slot |
| ready | output | 1 | One-cycle completion pulse |
| mul_start | output | 1 | Command pulse to the multiplier |
| mul_x | output | 2 | x operand slot of the command |
| mul_y | output | 2 | y operand slot of the command |
| mul_dst | output | 2 | Destination slot of the command |
| mul_done | input | 1 | Multiplier completion pulse |

## Verification
The hardest condition to reach from the ports is the boundary between entries. The last pair of one slice is finished, and the sequencer must pop the next entry instead of reporting ready. A wrong slice order or bit order there changes only the numerical result.

The bench attaches a behavioural multiplier that computes real products modulo a small prime. It runs exponents of one, two and eight entries, including the all-zero pair case and a queue filled to its limit with a discarded extra push. The final accumulator and the per-slot command counts are then compared with values obtained from an independent modular power.

// File: rtl/simexp_pkg.sv
// Shared types and constants for the simultaneous exponentiation sequencer.
// Assumes a 4-slot operand store addressed by 2-bit codes.
package simexp_pkg;

    localparam int SLOT_W = 2;
    localparam logic [SLOT_W-1:0] SLOT_ACC = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQR,
        ST_SQR_WAIT,
        ST_MUL_WAIT,
        ST_ADVANCE,
        ST_SGL_WAIT
    } seq_state_t;

    // Map a non-zero {e1,e0} bit pair to its precomputed operand slot.
    function automatic logic [SLOT_W-1:0] pair_slot(input logic [1:0] pair);
        return pair - 2'd1;
    endfunction

endpackage

// File: rtl/simexp_fifo.sv
// Entry queue for exponent material. Show-ahead read: rd_data is valid
// whenever empty is low. Pushes while full are discarded and flagged one
// cycle later. Assumes pop is only asserted while not empty.
module simexp_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_wr, do_rd;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = push && !full;
    assign do_rd   = pop && !empty;
    assign rd_data = mem[rd_ptr];

    // Next pointer value with wrap at the end of storage.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointers, occupancy and the discarded-push flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            drop   <= 1'b0;
        end else begin
            drop <= push && full;
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/simexp_pair_scan.sv
// Holds one queue entry split into its e1 and e0 slices and presents the
// current bit pair, most significant first. load replaces the entry;
// advance moves to the next lower pair. last marks the bottom pair.
module simexp_pair_scan #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:0] entry,
    output logic [1:0]        pair,
    output logic              last
);
    localparam int SLICE_W = DATA_W / 2;
    localparam int CNT_W   = $clog2(SLICE_W);

    logic [SLICE_W-1:0] hi_q, lo_q;
    logic [CNT_W-1:0]   left_q;

    assign pair = {hi_q[SLICE_W-1], lo_q[SLICE_W-1]};
    assign last = (left_q == '0);

    // Load a fresh entry or shift both slices up by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            hi_q   <= entry[DATA_W-1:SLICE_W];
            lo_q   <= entry[SLICE_W-1:0];
            left_q <= CNT_W'(SLICE_W - 1);
        end else if (advance) begin
            hi_q   <= {hi_q[SLICE_W-2:0], 1'b0};
            lo_q   <= {lo_q[SLICE_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/simexp_ctrl.sv
// Command sequencer. In auto mode it squares the accumulator for every bit
// pair and then multiplies by the slot the pair selects; in single mode it
// forwards the host's operand codes once. Assumes the multiplier answers
// each mul_start with exactly one mul_done at least one cycle later.
module simexp_ctrl
    import simexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              auto_run,
    input  logic [SLOT_W-1:0] x_sel,
    input  logic [SLOT_W-1:0] y_sel,
    input  logic [SLOT_W-1:0] dst_sel,
    input  logic              q_empty,
    output logic              q_pop,
    output logic              scan_adv,
    input  logic [1:0]        pair,
    input  logic              last,
    input  logic              mul_done,
    output logic              mul_start,
    output logic [SLOT_W-1:0] mul_x,
    output logic [SLOT_W-1:0] mul_y,
    output logic [SLOT_W-1:0] mul_dst,
    output logic              ready,
    output logic              busy,
    output logic              auto_q
);
    seq_state_t state;
    logic       idle_auto;

    assign busy      = (state != ST_IDLE);
    assign idle_auto = (state == ST_IDLE) && start && auto_run;
    // Fetch an entry on an auto start or when the current one is used up.
    assign q_pop     = !q_empty && (idle_auto || (state == ST_ADVANCE && last));
    // Step to the next lower pair inside the current entry.
    assign scan_adv  = (state == ST_ADVANCE) && !last;

    // State transitions and registered command/ready outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mul_start <= 1'b0;
            mul_x     <= '0;
            mul_y     <= '0;
            mul_dst   <= '0;
            ready     <= 1'b0;
            auto_q    <= 1'b0;
        end else begin
            mul_start <= 1'b0;
            ready     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && auto_run) begin
                        auto_q <= 1'b1;
                        if (q_empty) ready <= 1'b1;
                        else         state <= ST_SQR;
                    end else if (start) begin
                        auto_q    <= 1'b0;
                        mul_start <= 1'b1;
                        mul_x     <= x_sel;
                        mul_y     <= y_sel;
                        mul_dst   <= dst_sel;
                        state     <= ST_SGL_WAIT;
                    end
                end
                ST_SQR: begin
                    mul_start <= 1'b1;
                    mul_x     <= SLOT_ACC;
                    mul_y     <= SLOT_ACC;
                    mul_dst   <= SLOT_ACC;
                    state     <= ST_SQR_WAIT;
                end
                ST_SQR_WAIT: begin
                    if (mul_done) begin
                        if (pair != 2'b00) begin
                            mul_start <= 1'b1;
                            mul_x     <= SLOT_ACC;
                            mul_y     <= pair_slot(pair);
                            mul_dst   <= SLOT_ACC;
                            state     <= ST_MUL_WAIT;
                        end else begin
                            state <= ST_ADVANCE;
                        end
                    end
                end
                ST_MUL_WAIT: begin
                    if (mul_done) state <= ST_ADVANCE;
                end
                ST_ADVANCE: begin
                    if (last && q_empty) begin
                        ready <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_SQR;
                    end
                end
                ST_SGL_WAIT: begin
                    if (mul_done) begin
                        ready <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/simexp_seq.sv
// Top level of the dual-exponent sequencer: entry queue, pair scanner and
// command sequencer. The multiplier and operand store are external.
module simexp_seq #(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] fifo_din,
    input  logic              fifo_push,
    output logic              fifo_full,
    output logic              fifo_drop,
    input  logic              start,
    input  logic              auto_run,
    input  logic [1:0]        x_sel,
    input  logic [1:0]        y_sel,
    input  logic [1:0]        dst_sel,
    output logic              ready,
    output logic              mul_start,
    output logic [1:0]        mul_x,
    output logic [1:0]        mul_y,
    output logic [1:0]        mul_dst,
    input  logic              mul_done
);
    logic [DATA_W-1:0] q_head;
    logic              fifo_empty, q_pop, scan_adv, last, busy, run_auto_q;
    logic [1:0]        pair;

    simexp_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (fifo_push),
        .wr_data (fifo_din),
        .pop     (q_pop),
        .rd_data (q_head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .drop    (fifo_drop)
    );

    simexp_pair_scan #(.DATA_W(DATA_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (q_pop),
        .advance (scan_adv),
        .entry   (q_head),
        .pair    (pair),
        .last    (last)
    );

    simexp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .auto_run  (auto_run),
        .x_sel     (x_sel),
        .y_sel     (y_sel),
        .dst_sel   (dst_sel),
        .q_empty   (fifo_empty),
        .q_pop     (q_pop),
        .scan_adv  (scan_adv),
        .pair      (pair),
        .last      (last),
        .mul_done  (mul_done),
        .mul_start (mul_start),
        .mul_x     (mul_x),
        .mul_y     (mul_y),
        .mul_dst   (mul_dst),
        .ready     (ready),
        .busy      (busy),
        .auto_q    (run_auto_q)
    );
endmodule

// File: rtl/simexp_seq_chk.sv
// Protocol checker for simexp_seq, attached by bind. Tracks whether a
// multiplier command is outstanding and checks the handshake rules.
module simexp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_push,
    input logic       fifo_full,
    input logic       fifo_drop,
    input logic       fifo_empty,
    input logic       start,
    input logic       auto_run,
    input logic [1:0] x_sel,
    input logic [1:0] y_sel,
    input logic [1:0] dst_sel,
    input logic       ready,
    input logic       mul_start,
    input logic [1:0] mul_x,
    input logic [1:0] mul_dst,
    input logic [1:0] mul_y,
    input logic       mul_done,
    input logic       busy,
    input logic       run_auto_q
);
    logic pending;

    // Outstanding-command tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (mul_start) pending <= 1'b1;
        else if (mul_done)  pending <= 1'b0;
    end

    p_drop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_full) |=> fifo_drop);
    p_no_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_full) |=> !fifo_drop);
    p_acc_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_start && run_auto_q) |-> (mul_x == 2'd3 && mul_dst == 2'd3));
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    p_empty_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && auto_run && fifo_empty) |=> (ready && !mul_start));
    p_single_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !auto_run) |=>
        (mul_start && mul_x == $past(x_sel) && mul_y == $past(y_sel)
         && mul_dst == $past(dst_sel)));
    p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |=> !mul_start);
    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> !pending);
endmodule

bind simexp_seq simexp_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_push  (fifo_push),
    .fifo_full  (fifo_full),
    .fifo_drop  (fifo_drop),
    .fifo_empty (fifo_empty),
    .start      (start),
    .auto_run   (auto_run),
    .x_sel      (x_sel),
    .y_sel      (y_sel),
    .dst_sel    (dst_sel),
    .ready      (ready),
    .mul_start  (mul_start),
    .mul_x      (mul_x),
    .mul_dst    (mul_dst),
    .mul_y      (mul_y),
    .mul_done   (mul_done),
    .busy       (busy),
    .run_auto_q (run_auto_q)
);

// File: tb/sim_simexp_seq.sv
// Directed bench: a behavioural multiplier computes real products modulo a
// small prime on four operand slots; each task checks its own results.
module sim_simexp_seq;
    localparam longint MODP  = 1000003;
    localparam int     LAT   = 3;
    localparam int     DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fifo_din = '0;
    logic        fifo_push = 1'b0, start = 1'b0, auto_run = 1'b0;
    logic [1:0]  x_sel = '0, y_sel = '0, dst_sel = '0;
    logic        fifo_full, fifo_drop, ready, mul_start;
    logic [1:0]  mul_x, mul_y, mul_dst;
    logic        model_done = 1'b0, stray_done = 1'b0;
    wire         mul_done = model_done | stray_done;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    simexp_seq #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_din(fifo_din), .fifo_push(fifo_push),
        .fifo_full(fifo_full), .fifo_drop(fifo_drop), .start(start),
        .auto_run(auto_run), .x_sel(x_sel), .y_sel(y_sel), .dst_sel(dst_sel),
        .ready(ready), .mul_start(mul_start), .mul_x(mul_x), .mul_y(mul_y),
        .mul_dst(mul_dst), .mul_done(mul_done)
    );

    // Behavioural multiplier with fixed latency.
    longint slot [4];
    longint m_res;
    logic [1:0] m_dst;
    int m_cnt = 0;
    logic m_busy = 1'b0;
    always @(posedge clk) begin
        model_done <= 1'b0;
        if (m_busy) begin
            if (m_cnt == 0) begin
                model_done  <= 1'b1;
                slot[m_dst] <= m_res;
                m_busy      <= 1'b0;
            end else m_cnt <= m_cnt - 1;
        end else if (mul_start) begin
            m_busy <= 1'b1;
            m_cnt  <= LAT - 1;
            m_res  <= (slot[mul_x] * slot[mul_y]) % MODP;
            m_dst  <= mul_dst;
        end
    end

    // Monitor at the falling edge.
    int cyc = 0, op_cnt = 0, sq_cnt = 0, rdy_cnt = 0, done_cyc = 0, rdy_cyc = 0;
    int ycnt [3];
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mul_start) begin
            op_cnt <= op_cnt + 1;
            if (mul_x == 2'd3 && mul_y == 2'd3 && mul_dst == 2'd3) sq_cnt <= sq_cnt + 1;
            else if (mul_x == 2'd3 && mul_dst == 2'd3) ycnt[mul_y] <= ycnt[mul_y] + 1;
        end
        if (mul_done) done_cyc <= cyc;
        if (ready) begin rdy_cnt <= rdy_cnt + 1; rdy_cyc <= cyc; end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint pow_mod(input longint b, input longint e);
        longint r = 1;
        b = b % MODP;
        while (e > 0) begin
            if (e[0]) r = (r * b) % MODP;
            b = (b * b) % MODP;
            e = e >>> 1;
        end
        return r;
    endfunction

    longint g0 = 123457, g1 = 765431;
    logic [31:0] ents [16];
    int n_ent = 0;

    task automatic init_slots();
        slot[0] = g0; slot[1] = g1; slot[2] = (g0 * g1) % MODP; slot[3] = 1;
    endtask

    task automatic push(input logic [31:0] w, input bit keep);
        @(negedge clk); fifo_din = w; fifo_push = 1'b1;
        @(negedge clk); fifo_push = 1'b0;
        if (keep) begin ents[n_ent] = w; n_ent++; end
    endtask

    task automatic pulse_start(input bit au, input logic [1:0] x, input logic [1:0] y, input logic [1:0] d);
        @(negedge clk); auto_run = au; x_sel = x; y_sel = y; dst_sel = d; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Full auto run over the queued entries, optional start poke while busy.
    task automatic run_auto(input string name, input bit poke);
        longint expv = 1;
        int e_sq, e0c = 0, e1c = 0, e2c = 0, r0, t;
        e_sq = 16 * n_ent;
        for (int k = 0; k < n_ent; k++) begin
            expv = pow_mod(expv, 65536);
            expv = (expv * pow_mod(g0, longint'(ents[k][15:0]))) % MODP;
            expv = (expv * pow_mod(g1, longint'(ents[k][31:16]))) % MODP;
            e0c += $countones(~ents[k][31:16] & ents[k][15:0]);
            e1c += $countones(ents[k][31:16] & ~ents[k][15:0]);
            e2c += $countones(ents[k][31:16] & ents[k][15:0]);
        end
        init_slots();
        @(negedge clk);
        op_cnt = 0; sq_cnt = 0; ycnt[0] = 0; ycnt[1] = 0; ycnt[2] = 0;
        r0 = rdy_cnt;
        pulse_start(1'b1, 2'd0, 2'd0, 2'd0);
        if (poke) begin
            repeat (6) @(negedge clk);
            pulse_start(1'b0, 2'd0, 2'd1, 2'd0);
        end
        t = 0;
        while (rdy_cnt == r0 && t < 30000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        #1;
        check(slot[3] == expv, {name, " R5 R1 accumulator"}, slot[3], expv);
        check(sq_cnt == e_sq, {name, " R3 R5 squarings"}, sq_cnt, e_sq);
        check(ycnt[0] == e0c && ycnt[1] == e1c && ycnt[2] == e2c, {name, " R4 slot counts"},
              ycnt[0] * 10000 + ycnt[1] * 100 + ycnt[2], e0c * 10000 + e1c * 100 + e2c);
        check(op_cnt == e_sq + e0c + e1c + e2c, {name, " R4 R9 total commands"}, op_cnt, e_sq + e0c + e1c + e2c);
        check(rdy_cnt == r0 + 1, {name, " R6 single ready pulse"}, rdy_cnt - r0, 1);
        check(rdy_cyc - done_cyc == 2, {name, " R6 ready timing"}, rdy_cyc - done_cyc, 2);
        n_ent = 0;
    endtask

    task automatic t_reset();
        #1;
        check(!ready && !mul_start, "R6 reset outputs idle", {ready, mul_start}, 0);
        check(!fifo_full && !fifo_drop, "R2 reset queue flags", {fifo_full, fifo_drop}, 0);
    endtask

    task automatic t_empty_auto();
        int r0 = rdy_cnt, o0 = op_cnt;
        @(negedge clk); auto_run = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0; #1;
        check(ready == 1'b1, "R7 ready next cycle on empty queue", ready, 1);
        @(negedge clk); #1;
        check(ready == 1'b0, "R7 R6 ready one cycle", ready, 0);
        repeat (3) @(negedge clk); #1;
        check(op_cnt == o0 && rdy_cnt == r0 + 1, "R7 no command issued", op_cnt - o0, 0);
    endtask

    task automatic t_single();
        longint expv;
        int t = 0, r0 = rdy_cnt;
        init_slots();
        expv = (slot[1] * slot[2]) % MODP;
        @(negedge clk); auto_run = 1'b0; x_sel = 2'd1; y_sel = 2'd2; dst_sel = 2'd0; start = 1'b1;
        @(negedge clk); start = 1'b0; #1;
        check(mul_start && mul_x == 2'd1 && mul_y == 2'd2 && mul_dst == 2'd0,
              "R8 single command codes", {mul_start, mul_x, mul_y, mul_dst}, 7'b1011000);
        while (rdy_cnt == r0 && t < 100) begin @(negedge clk); t++; end
        #1;
        check(slot[0] == expv, "R8 single result slot", slot[0], expv);
        check(rdy_cyc - done_cyc == 1, "R8 ready after done", rdy_cyc - done_cyc, 1);
    endtask

    task automatic t_stray_done();
        int r0 = rdy_cnt, o0 = op_cnt;
        @(negedge clk); stray_done = 1'b1;
        @(negedge clk); stray_done = 1'b0;
        repeat (5) @(negedge clk); #1;
        check(rdy_cnt == r0 && op_cnt == o0, "R9 idle done ignored", rdy_cnt - r0 + op_cnt - o0, 0);
    endtask

    task automatic t_full();
        for (int k = 0; k < DEPTH; k++) push(32'h1357_9BDF ^ (32'h0F1E_2D3C * k), 1'b1);
        #1;
        check(fifo_full == 1'b1, "R2 full at depth", fifo_full, 1);
        @(negedge clk); fifo_din = 32'hDEAD_BEEF; fifo_push = 1'b1;
        @(negedge clk); fifo_push = 1'b0; #1;
        check(fifo_drop == 1'b1, "R2 drop after push while full", fifo_drop, 1);
        @(negedge clk); #1;
        check(fifo_drop == 1'b0, "R2 drop one cycle", fifo_drop, 0);
        run_auto("full", 1'b0);
        check(fifo_full == 1'b0, "R2 queue drained", fifo_full, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty_auto();
        t_single();
        t_stray_done();
        push(32'h5A3C_C0F1, 1'b1);
        run_auto("one", 1'b0);
        push(32'h0000_8001, 1'b1);
        push(32'hFFFF_0000, 1'b1);
        run_auto("two", 1'b0);
        push(32'h0F0F_3C3C, 1'b1);
        run_auto("poke R9", 1'b1);
        t_full();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule